// File: doc/BRIEF.md
# Command-Response Buffer Register Interface

This block is the device-side register file and control logic of a memory-mapped command-response buffer on a security coprocessor. A host reaches it through a simple 32-bit bus. Single-cycle write strobes and registered reads give access to the control registers in the low 128 bytes and to a shared command/response buffer that starts at byte 0x80.

The host first claims the single locality and then moves the device from idle to ready through a request register. It places a command in the buffer and rings the start doorbell. A stub execution engine stands in for real command processing. It stays busy for a fixed number of cycles, writes a fixed 10-byte response header at the front of the buffer, raises a completion flag and clears the start register. A cancel request cuts the busy period short, and in that case no response is written. Both power transitions are request/acknowledge handshakes. The host polls them through the request and status registers.

Top module: `cmdbuf_regif`

## Requirements
- R1: After reset the locality state word (0x00) reads 0x81: bit 7 valid and bit 0 established are always 1, and bit 1 assigned is 0. The control status (0x44) reads 0x2 with bit 1 idle set and bit 0 error clear. The control request (0x40), start (0x4C), cancel (0x48), interrupt enable (0x50) and interrupt status (0x54) read 0.
- R2: The interface ID (0x30) reads 0x1. The command size (0x58) and response size (0x64) both read BUF_BYTES. The command address low word (0x5C) and response address low word (0x68) read 0x80. Their high words (0x60, 0x6C) read 0.
- R3: Writing bit 0 of the locality control word (0x08) sets assigned, which shows as bit 1 of 0x00 and bit 0 of the locality status word (0x0C). Writing bit 1 clears assigned. If both bits are written together, relinquish wins. The locality control word itself reads 0.
- R4: Writing bit 0 (go ready) or bit 1 (go idle) of 0x40 sets the matching pending bit, which reads back at 0x40. PWR_CYCLES cycles later the pending bits clear. At that point the idle flag (bit 1 of 0x44) becomes 0 for a ready request and 1 for an idle request. If both are pending, idle wins.
- R5: A write with bit 0 set to start (0x4C) launches a command only while the locality is assigned and the device is ready. A start write in any other case, and any write with bit 0 clear, leaves start at 0.
- R6: An accepted start reads 1 for BUSY_CYCLES cycles and then clears. At that point the buffer words at 0x80, 0x84 and 0x88 hold 0x00000180, 0x00000A00 and 0x00000000. On the byte lanes (byte k of a word sits at bits 8k+7..8k) these are bytes 0x80 0x01, a big-endian length of 10 in bytes 2..5, and zeros in bytes 6..11. Bit 0 of the interrupt status (0x54) is also set.
- R7: Bit 0 of cancel (0x48) is stored and reads back. While it is set, a running command stops on the next cycle: start clears, no header is written, and the interrupt status is not set. Writing 0 clears the cancel, after which a new start works normally.
- R8: Only bit 31 of the interrupt enable (0x50) is stored, so its other bits read 0. Writing 1 to bit 0 of the interrupt status clears the completion flag.
- R9: The buffer words from 0x80 to 0x80+BUF_BYTES-1 are read/write storage. Unmapped addresses read 0, and writes to them change nothing.
- R10: Read data and hostRdValid appear one cycle after hostRdEn. hostRdValid is low in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Write strobe |
| hostRdEn | input | 1 | Read strobe |
| hostAddr | input | ADDR_W | Byte address (word aligned) |
| hostWrData | input | 32 | Write data |
| hostRdData | output | 32 | Read data, registered |
| hostRdValid | output | 1 | Read data valid |

## Verification
The assertions check on every cycle that:
- a start only rises from a granted, ready state;
- a set cancel ends a run on the next cycle;
- a power transition always resolves to the requested idle value, with idle winning over ready;
- the header strobe always leaves the correct first word and the completion flag behind;
- read valid tracks the read strobe.

Only the bench scenarios can show the following:
- the exact busy length;
- that a cancelled run leaves the buffer untouched;
- that the buffer contents survive random traffic;
- that rejected starts and writes to unmapped addresses are truly ignored.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  localparam int BUF_BASE = 'h80;

  // control-region word offsets (low 7 address bits)
  localparam logic [6:0] OFS_LOC_STATE = 7'h00;
  localparam logic [6:0] OFS_LOC_CTRL  = 7'h08;
  localparam logic [6:0] OFS_LOC_STS   = 7'h0C;
  localparam logic [6:0] OFS_IFACE_ID  = 7'h30;
  localparam logic [6:0] OFS_CTRL_REQ  = 7'h40;
  localparam logic [6:0] OFS_CTRL_STS  = 7'h44;
  localparam logic [6:0] OFS_CANCEL    = 7'h48;
  localparam logic [6:0] OFS_START     = 7'h4C;
  localparam logic [6:0] OFS_INT_EN    = 7'h50;
  localparam logic [6:0] OFS_INT_STS   = 7'h54;
  localparam logic [6:0] OFS_CMD_SIZE  = 7'h58;
  localparam logic [6:0] OFS_CMD_ADDR  = 7'h5C;
  localparam logic [6:0] OFS_RSP_SIZE  = 7'h64;
  localparam logic [6:0] OFS_RSP_ADDR  = 7'h68;

  // fixed stub response: tag 0x80 0x01, big-endian length 10, zero code
  localparam logic [15:0] RSP_TAG = 16'h8001;
  localparam logic [31:0] RSP_LEN = 32'd10;
  localparam logic [31:0] HDR_WORD0 = {RSP_LEN[23:16], RSP_LEN[31:24], RSP_TAG[7:0], RSP_TAG[15:8]};
  localparam logic [31:0] HDR_WORD1 = {16'h0000, RSP_LEN[7:0], RSP_LEN[15:8]};
  localparam logic [31:0] HDR_WORD2 = 32'h0000_0000;

  typedef struct packed {
    logic writeHeader;
  } ctrlStrobe_t;

  typedef struct packed {
    logic       assigned;
    logic       idle;
    logic [1:0] pendReq;
    logic       start;
    logic       cancel;
    logic       intEnable;
    logic       doneFlag;
  } ctrlView_t;

endpackage

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BUSY_CYCLES = 20,
  parameter int PWR_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output ctrlView_t         view,
  output ctrlStrobe_t       strobe
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int PWR_W  = $clog2(PWR_CYCLES + 1);

  logic              ctrlSel;
  logic [6:0]        off;
  logic              wLocCtrl, wCtrlReq, wCancel, wStart, wIntEn, wIntSts;
  logic              assigned, idle, start, cancel, intEnable, doneFlag;
  logic [1:0]        pendReq;
  logic [PWR_W-1:0]  pwrCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              pwrDone, headerNow;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData[30:2];

  assign ctrlSel  = (addr[ADDR_W-1:7] == '0);
  assign off      = addr[6:0];
  assign wLocCtrl = wrEn && ctrlSel && (off == OFS_LOC_CTRL);
  assign wCtrlReq = wrEn && ctrlSel && (off == OFS_CTRL_REQ);
  assign wCancel  = wrEn && ctrlSel && (off == OFS_CANCEL);
  assign wStart   = wrEn && ctrlSel && (off == OFS_START);
  assign wIntEn   = wrEn && ctrlSel && (off == OFS_INT_EN);
  assign wIntSts  = wrEn && ctrlSel && (off == OFS_INT_STS);

  assign pwrDone   = (pendReq != 2'b00) && (pwrCnt == PWR_W'(1));
  assign headerNow = start && !cancel && (busyCnt == BUSY_W'(1));

  // locality handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assigned <= 1'b0;
    end else if (wLocCtrl) begin
      if (wrData[1])      assigned <= 1'b0;
      else if (wrData[0]) assigned <= 1'b1;
    end
  end

  // idle / ready transitions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReq <= 2'b00;
      pwrCnt  <= '0;
      idle    <= 1'b1;
    end else begin
      if (pwrDone) begin
        idle    <= pendReq[1];
        pendReq <= 2'b00;
      end else if (pendReq != 2'b00) begin
        pwrCnt <= pwrCnt - PWR_W'(1);
      end
      if (wCtrlReq && (wrData[1:0] != 2'b00)) begin
        pendReq <= (pwrDone ? 2'b00 : pendReq) | wrData[1:0];
        if (pwrDone || pendReq == 2'b00) pwrCnt <= PWR_W'(PWR_CYCLES);
      end
    end
  end

  // start doorbell and stub execution engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      start   <= 1'b0;
      busyCnt <= '0;
    end else if (start) begin
      if (cancel || busyCnt == BUSY_W'(1)) start <= 1'b0;
      else                                  busyCnt <= busyCnt - BUSY_W'(1);
    end else if (wStart && wrData[0] && assigned && !idle) begin
      start   <= 1'b1;
      busyCnt <= BUSY_W'(BUSY_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cancel    <= 1'b0;
      intEnable <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      if (wCancel) cancel <= wrData[0];
      if (wIntEn)  intEnable <= wrData[31];
      if (headerNow)                doneFlag <= 1'b1;
      else if (wIntSts && wrData[0]) doneFlag <= 1'b0;
    end
  end

  assign view.assigned  = assigned;
  assign view.idle      = idle;
  assign view.pendReq   = pendReq;
  assign view.start     = start;
  assign view.cancel    = cancel;
  assign view.intEnable = intEnable;
  assign view.doneFlag  = doneFlag;
  assign strobe.writeHeader = headerNow;

  // R4: a pending transition always has a running countdown
  a_r4_pending_counts: assert property (@(posedge clk) disable iff (!rstN)
    (pendReq != 2'b00) |-> (pwrCnt != '0));
  // R4: an idle request resolves to idle, even when ready was also asked
  a_r4_idle_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendReq[1]) && pendReq == 2'b00) |-> idle);
  // R4: a lone ready request resolves to not idle
  a_r4_ready_clears_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendReq) == 2'b01 && pendReq == 2'b00) |-> !idle);
  // R5: start only rises from an assigned, ready state
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(start) |-> ($past(assigned) && !$past(idle)));
  // R7: a set cancel ends a running command on the next cycle
  a_r7_cancel_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (start && cancel) |=> !start);
  // R6: the header strobe ends the run and raises completion
  a_r6_header_ends_run: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHeader |=> (!start && doneFlag));

endmodule

// File: rtl/cmdbuf_data.sv
module cmdbuf_data
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  ctrlView_t         view,
  input  ctrlStrobe_t       strobe,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam logic [ADDR_W:0] BASE_EXT = (ADDR_W + 1)'(BUF_BASE);
  localparam logic [ADDR_W:0] END_EXT  = (ADDR_W + 1)'(BUF_BASE + BUF_BYTES);

  logic [31:0]     bufMem [BUF_WORDS];
  logic [ADDR_W:0] addrExt, bufOff;
  logic            bufSel, ctrlSel;
  logic [IDX_W-1:0] bufIdx;
  logic [31:0]     rdNext;
  logic            unusedOffBits;

  assign addrExt = {1'b0, addr};
  assign bufOff  = addrExt - BASE_EXT;
  assign bufSel  = (addrExt >= BASE_EXT) && (addrExt < END_EXT);
  assign ctrlSel = (addr[ADDR_W-1:7] == '0);
  assign bufIdx  = bufOff[IDX_W+1:2];
  assign unusedOffBits = ^{bufOff[ADDR_W:IDX_W+2], bufOff[1:0]};

  always_ff @(posedge clk) begin
    if (strobe.writeHeader) begin
      bufMem[0] <= HDR_WORD0;
      bufMem[1] <= HDR_WORD1;
      bufMem[2] <= HDR_WORD2;
    end else if (wrEn && bufSel) begin
      bufMem[bufIdx] <= wrData;
    end
  end

  always_comb begin
    rdNext = 32'h0;
    if (bufSel) begin
      rdNext = bufMem[bufIdx];
    end else if (ctrlSel) begin
      case (addr[6:0])
        OFS_LOC_STATE: rdNext = {24'h0, 1'b1, 5'b0, view.assigned, 1'b1};
        OFS_LOC_STS:   rdNext = {31'h0, view.assigned};
        OFS_IFACE_ID:  rdNext = 32'h1;
        OFS_CTRL_REQ:  rdNext = {30'h0, view.pendReq};
        OFS_CTRL_STS:  rdNext = {30'h0, view.idle, 1'b0};
        OFS_CANCEL:    rdNext = {31'h0, view.cancel};
        OFS_START:     rdNext = {31'h0, view.start};
        OFS_INT_EN:    rdNext = {view.intEnable, 31'h0};
        OFS_INT_STS:   rdNext = {31'h0, view.doneFlag};
        OFS_CMD_SIZE,
        OFS_RSP_SIZE:  rdNext = 32'(BUF_BYTES);
        OFS_CMD_ADDR,
        OFS_RSP_ADDR:  rdNext = 32'(BUF_BASE);
        default:       rdNext = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= 32'h0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end

  // R6: the header strobe leaves the tag and length-high bytes in word 0
  a_r6_header_word0: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHeader |=> (bufMem[0] == HDR_WORD0));
  // R10: a read strobe is answered on the next cycle
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  // R10: no valid without a read
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

endmodule

// File: rtl/cmdbuf_regif.sv
module cmdbuf_regif
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BUF_BYTES   = 256,
  parameter int BUSY_CYCLES = 20,
  parameter int PWR_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              hostRdValid
);

  ctrlView_t   view;
  ctrlStrobe_t strobe;

  cmdbuf_ctrl #(
    .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES), .PWR_CYCLES(PWR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .addr(hostAddr),
    .wrData(hostWrData), .view(view), .strobe(strobe)
  );

  cmdbuf_data #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .rdEn(hostRdEn), .addr(hostAddr),
    .wrData(hostWrData), .view(view), .strobe(strobe),
    .rdData(hostRdData), .rdValid(hostRdValid)
  );

endmodule

// File: tb/cmdbuf_regif_bench.sv
module cmdbuf_regif_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 12;
  localparam int BUF_BYTES   = 256;
  localparam int BUF_WORDS   = BUF_BYTES / 4;
  localparam int BUSY_CYCLES = 20;
  localparam int PWR_CYCLES  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostWrEn = 1'b0;
  logic              hostRdEn = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [31:0]       hostWrData = '0;
  logic [31:0]       hostRdData;
  logic              hostRdValid;

  int    numChecks = 0;
  int    numFails  = 0;
  bit    finished  = 1'b0;
  logic [31:0] expBuf [BUF_WORDS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmdbuf_regif #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES),
    .BUSY_CYCLES(BUSY_CYCLES), .PWR_CYCLES(PWR_CYCLES)
  ) u_cmdbuf_regif (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid)
  );

  function automatic logic [31:0] intEnExpect(logic [31:0] d);
    return d & 32'h8000_0000;
  endfunction

  function automatic logic [31:0] locStateExpect(bit granted);
    return granted ? 32'h83 : 32'h81;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idleCycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    hostWrEn   = 1'b1;
    hostAddr   = ADDR_W'(addr);
    hostWrData = data;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    hostRdEn = 1'b1;
    hostAddr = ADDR_W'(addr);
    @(posedge clk);
    @(negedge clk);
    hostRdEn = 1'b0;
    data = hostRdData;
    if (!hostRdValid) begin
      numChecks++;
      numFails++;
      $display("FAIL R10: actual valid 0 expected 1 at 0x%03h", addr);
    end
  endtask

  task automatic readCheck(string req, int addr, logic [31:0] exp);
    logic [31:0] d;
    busRead(addr, d);
    check(req, d, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      numFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int seedInit;
    seedInit = $urandom(32'd20931);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck("R1 loc state", 'h00, 32'h81);
    readCheck("R1 ctrl status", 'h44, 32'h2);
    readCheck("R1 ctrl request", 'h40, 32'h0);
    readCheck("R1 start", 'h4C, 32'h0);
    readCheck("R1 cancel", 'h48, 32'h0);
    readCheck("R1 int enable", 'h50, 32'h0);
    readCheck("R1 int status", 'h54, 32'h0);

    // R10: valid drops after an idle cycle
    idleCycles(1);
    check("R10 valid low", {31'h0, hostRdValid}, 32'h0);

    // R2 identification and buffer description
    readCheck("R2 iface id", 'h30, 32'h1);
    readCheck("R2 cmd size", 'h58, 32'(BUF_BYTES));
    readCheck("R2 rsp size", 'h64, 32'(BUF_BYTES));
    readCheck("R2 cmd addr low", 'h5C, 32'h80);
    readCheck("R2 cmd addr high", 'h60, 32'h0);
    readCheck("R2 rsp addr low", 'h68, 32'h80);
    readCheck("R2 rsp addr high", 'h6C, 32'h0);

    // R5: start without locality or readiness is ignored
    busWrite('h4C, 32'h1);
    readCheck("R5 start no grant", 'h4C, 32'h0);

    // R3 locality handshake
    busWrite('h08, 32'h1);
    readCheck("R3 loc state granted", 'h00, locStateExpect(1'b1));
    readCheck("R3 loc status", 'h0C, 32'h1);
    readCheck("R3 loc ctrl reads 0", 'h08, 32'h0);
    busWrite('h08, 32'h2);
    readCheck("R3 relinquish", 'h00, locStateExpect(1'b0));
    busWrite('h08, 32'h1);
    busWrite('h08, 32'h3);
    readCheck("R3 relinquish wins", 'h00, locStateExpect(1'b0));
    busWrite('h08, 32'h1);

    // R5: granted but still idle
    busWrite('h4C, 32'h1);
    readCheck("R5 start while idle", 'h4C, 32'h0);

    // R4 go ready
    busWrite('h40, 32'h1);
    readCheck("R4 ready pending", 'h40, 32'h1);
    idleCycles(PWR_CYCLES + 2);
    readCheck("R4 ready request cleared", 'h40, 32'h0);
    readCheck("R4 not idle", 'h44, 32'h0);

    // R8 random interrupt-enable patterns
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = $urandom;
      busWrite('h50, v);
      readCheck("R8 int enable", 'h50, intEnExpect(v));
    end

    // R9 random buffer traffic against a model
    for (int w = 0; w < BUF_WORDS; w++) begin
      expBuf[w] = 32'(w) * 32'h0101_0101;
      busWrite('h80 + 4 * w, expBuf[w]);
    end
    for (int i = 0; i < 40; i++) begin
      int w;
      logic [31:0] v;
      w = int'($urandom_range(BUF_WORDS - 1, 0));
      v = $urandom;
      expBuf[w] = v;
      busWrite('h80 + 4 * w, v);
    end
    for (int w = 0; w < BUF_WORDS; w++) begin
      readCheck("R9 buffer word", 'h80 + 4 * w, expBuf[w]);
    end
    busWrite('h80 + BUF_BYTES, 32'hDEAD_BEEF);
    readCheck("R9 unmapped reads 0", 'h80 + BUF_BYTES, 32'h0);
    readCheck("R9 buffer end intact", 'h80 + BUF_BYTES - 4, expBuf[BUF_WORDS - 1]);
    readCheck("R9 gap reads 0", 'h38, 32'h0);

    // R6 normal completion
    for (int w = 0; w < 4; w++) begin
      expBuf[w] = 32'hFFFF_FFFF;
      busWrite('h80 + 4 * w, expBuf[w]);
    end
    busWrite('h4C, 32'h1);
    readCheck("R6 start busy", 'h4C, 32'h1);
    idleCycles(BUSY_CYCLES + 3);
    readCheck("R6 start cleared", 'h4C, 32'h0);
    readCheck("R6 header word0", 'h80, 32'h0000_0180);
    readCheck("R6 header word1", 'h84, 32'h0000_0A00);
    readCheck("R6 header word2", 'h88, 32'h0);
    readCheck("R6 word3 untouched", 'h8C, expBuf[3]);
    readCheck("R6 int status set", 'h54, 32'h1);
    busWrite('h54, 32'h1);
    readCheck("R8 int status cleared", 'h54, 32'h0);

    // R7 cancel
    busWrite('h80, 32'h1234_5678);
    busWrite('h4C, 32'h1);
    busWrite('h48, 32'h1);
    readCheck("R7 cancel reads back", 'h48, 32'h1);
    idleCycles(2);
    readCheck("R7 start aborted", 'h4C, 32'h0);
    idleCycles(BUSY_CYCLES + 3);
    readCheck("R7 no header", 'h80, 32'h1234_5678);
    readCheck("R7 no completion", 'h54, 32'h0);
    busWrite('h48, 32'h0);
    readCheck("R7 cancel cleared", 'h48, 32'h0);
    busWrite('h4C, 32'h1);
    readCheck("R7 restart accepted", 'h4C, 32'h1);
    idleCycles(BUSY_CYCLES + 3);
    readCheck("R7 restart completes", 'h80, 32'h0000_0180);

    // R5 a write of 0 does not start
    busWrite('h4C, 32'h0);
    readCheck("R5 zero write", 'h4C, 32'h0);

    // R4 go idle, then start rejected
    busWrite('h40, 32'h2);
    readCheck("R4 idle pending", 'h40, 32'h2);
    idleCycles(PWR_CYCLES + 2);
    readCheck("R4 idle reached", 'h44, 32'h2);
    busWrite('h4C, 32'h1);
    readCheck("R5 start after idle", 'h4C, 32'h0);

    // R4 both requests: idle wins
    busWrite('h40, 32'h1);
    idleCycles(PWR_CYCLES + 2);
    readCheck("R4 ready again", 'h44, 32'h0);
    busWrite('h40, 32'h3);
    idleCycles(PWR_CYCLES + 2);
    readCheck("R4 idle wins", 'h44, 32'h2);
    readCheck("R4 both cleared", 'h40, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

endmodule